// File: doc/BRIEF.md
# Rotated-Operand Self-Checking ALU

This block is an ALU of `WIDTH` operand bits that checks its own answer by computing it twice on the same hardware. The datapath is `WIDTH+1` slices wide. In the first pass the operands sit in the low `WIDTH` slices and the top slice holds a zero. For additions and subtractions that top slice catches the carry. In the second pass both operands are rotated left by `ROT` slices and computed again. The answer is rotated back and compared over all `WIDTH+1` bits with the first answer. Any difference raises `error`.

A fault in a slice therefore corrupts different bit positions in the two passes, so it shows up as a mismatch. The second pass needs only two fixed rotation networks and a movable cut in the ripple carry chain. The cut sits at slice 0 in the first pass and at slice `ROT mod (WIDTH+1)` in the second. The carry leaving the last slice wraps round to slice 0.

An operation starts with a one-cycle `start` pulse. Result, carry and error appear together with a one-cycle `done` pulse. For testing, the `fault_mask` and `fault_value` inputs force the outputs of chosen slices to fixed values in both passes, which models stuck-at faults.

Top module: `rro_alu`

## Requirements
- R1: Operation codes 0, 1 and 2 give `a AND b`, `a OR b` and `a XOR b`, each with `carry` 0.
- R2: Code 3 adds: `result` is the low `WIDTH` bits of `a+b` and `carry` is bit `WIDTH` of the sum.
- R3: Code 4 subtracts as `a + ~b + 1`: `result` is `a-b` modulo 2^WIDTH and `carry` is 1 exactly when `a >= b`.
- R4: Codes 5, 6 and 7 behave as code 0 (AND).
- R5: Timing and hold:
  - A `start` that is sampled high while the block is idle is accepted.
  - `done` is then high for exactly one cycle, after the second rising edge counted from and including the accepting edge.
  - `result`, `carry` and `error` change only at the edge that raises `done`.
- R6: A `start` that arrives during the checking cycle is ignored and produces no further `done`.
- R7: With `fault_mask` all zero, `error` is never raised.
- R8: Fault injection:
  - A set bit j of `fault_mask` forces the output of physical slice j to `fault_value[j]` in both passes.
  - `{carry, result}` reports the first-pass value.
  - For every slice and both stuck values, some operand pattern raises `error`.
- R9: `error` equals the inequality of two (WIDTH+1)-bit values. One is the true answer with logical bits j forced. The other is the true answer with logical bits (j-ROT) mod (WIDTH+1) forced.
- R10: For logic codes, any circular burst of at most `ROT mod WIDTH` adjacent faulty slices that makes the reported value wrong raises `error`.
- R11: For codes 3 and 4, any circular burst of at most `(ROT mod (WIDTH+1)) - 1` adjacent faulty slices that makes the reported value wrong raises `error`.
- R12: After reset, `done`, `result`, `carry` and `error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation with the present `op`, `a`, `b` |
| op | input | 3 | Operation code (R1 to R4) |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| fault_mask | input | WIDTH+1 | Slices whose output is forced |
| fault_value | input | WIDTH+1 | Forced value per slice |
| result | output | WIDTH | First-pass result |
| carry | output | 1 | First-pass top slice (carry or no-borrow) |
| error | output | 1 | Two passes disagreed |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hard case is a fault that hides itself. This happens when the stuck value equals the true bit at both positions the slice serves in the two passes, so pass one and pass two agree although a slice is broken. Another hard case is a burst that wraps through the spare slice, where the carry cut must sit in the right place.

The stimulus covers every slice and both stuck values against all-zero, all-one and random operands. It also draws random circular bursts, including ones that cross slice 0 and the spare slice. Every outcome is compared with a bench model that forces the true value at the rotated positions.

// File: rtl/rro_pkg.sv
package rro_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_XOR = 3'd2,
        OP_ADD = 3'd3,
        OP_SUB = 3'd4
    } alu_op_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_CHECK = 1'b1
    } phase_e;

    // Unused codes fall back to AND.
    function automatic alu_op_e norm_op(input logic [2:0] code);
        case (code)
            3'd1:    return OP_OR;
            3'd2:    return OP_XOR;
            3'd3:    return OP_ADD;
            3'd4:    return OP_SUB;
            default: return OP_AND;
        endcase
    endfunction

endpackage

// File: rtl/rro_rotl.sv
// Fixed left rotation network: bit i moves to (i + SH) mod W.
module rro_rotl #(
    parameter int W  = 9,
    parameter int SH = 1
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int S = SH % W;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[(i + S) % W] = din[i];
    end
endmodule

// File: rtl/rro_slices.sv
// WIDTH+1 bit slices with a ripple chain that starts at slice `cut`
// and wraps from the top slice to slice 0.
module rro_slices
    import rro_pkg::*;
#(
    parameter int DW = 9,
    parameter int CW = $clog2(DW)
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            cin,
    input  logic [CW-1:0]   cut,
    input  logic [DW-1:0]   fault_mask,
    input  logic [DW-1:0]   fault_value,
    output logic [DW-1:0]   y,
    output logic            chain_out
);
    localparam logic [CW:0] DW_L = (CW+1)'(DW);

    logic [DW-1:0] sum_v;
    logic [DW-1:0] raw_v;
    logic          c_w;
    logic [CW:0]   pos_w;
    logic [CW-1:0] idx_w;

    always_comb begin
        sum_v = '0;
        c_w   = cin;
        pos_w = '0;
        idx_w = '0;
        for (int j = 0; j < DW; j++) begin
            pos_w = {1'b0, cut} + (CW+1)'(j);
            if (pos_w >= DW_L) pos_w = pos_w - DW_L;
            idx_w = pos_w[CW-1:0];
            sum_v[idx_w] = a[idx_w] ^ b[idx_w] ^ c_w;
            c_w = (a[idx_w] & b[idx_w]) | (c_w & (a[idx_w] ^ b[idx_w]));
        end
        chain_out = c_w;
    end

    always_comb begin
        case (op)
            OP_OR:          raw_v = a | b;
            OP_XOR:         raw_v = a ^ b;
            OP_ADD, OP_SUB: raw_v = sum_v;
            default:        raw_v = a & b;
        endcase
        y = (raw_v & ~fault_mask) | (fault_value & fault_mask);
    end
endmodule

// File: rtl/rro_alu.sv
module rro_alu
    import rro_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int ROT   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH:0]   fault_mask,
    input  logic [WIDTH:0]   fault_value,
    output logic [WIDTH-1:0] result,
    output logic             carry,
    output logic             error,
    output logic             done
);
    localparam int DW    = WIDTH + 1;
    localparam int K_EFF = ROT % DW;
    localparam int CW    = $clog2(DW);
    localparam logic [CW-1:0] CUT_CHK = CW'(K_EFF);

    typedef struct packed {
        phase_e           phase;
        alu_op_e          op;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [DW-1:0]    ref_v;
        logic [WIDTH-1:0] result;
        logic             carry;
        logic             error;
        logic             done;
    } regs_t;

    regs_t cur_q, nxt_d;

    alu_op_e       in_op, dp_op;
    logic [DW-1:0] in_a, in_b, held_a, held_b, rot_a, rot_b;
    logic [DW-1:0] dp_a, dp_b, dp_y, back_y;
    logic [CW-1:0] dp_cut;
    logic          chain_out;

    // Operand preparation: spare slice zero, B inverted for subtraction.
    always_comb begin
        in_op  = norm_op(op);
        in_a   = {1'b0, a};
        in_b   = {1'b0, (in_op == OP_SUB) ? ~b : b};
        held_a = {1'b0, cur_q.a};
        held_b = {1'b0, (cur_q.op == OP_SUB) ? ~cur_q.b : cur_q.b};
    end

    rro_rotl #(.W(DW), .SH(K_EFF)) u_rot_a (.din(held_a), .dout(rot_a));
    rro_rotl #(.W(DW), .SH(K_EFF)) u_rot_b (.din(held_b), .dout(rot_b));

    always_comb begin
        if (cur_q.phase == PH_IDLE) begin
            dp_op  = in_op;
            dp_a   = in_a;
            dp_b   = in_b;
            dp_cut = '0;
        end else begin
            dp_op  = cur_q.op;
            dp_a   = rot_a;
            dp_b   = rot_b;
            dp_cut = CUT_CHK;
        end
    end

    rro_slices #(.DW(DW), .CW(CW)) u_slices (
        .op          (dp_op),
        .a           (dp_a),
        .b           (dp_b),
        .cin         (dp_op == OP_SUB),
        .cut         (dp_cut),
        .fault_mask  (fault_mask),
        .fault_value (fault_value),
        .y           (dp_y),
        .chain_out   (chain_out)
    );

    rro_rotl #(.W(DW), .SH(DW - K_EFF)) u_unrot (.din(dp_y), .dout(back_y));

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        case (cur_q.phase)
            PH_IDLE: begin
                if (start) begin
                    nxt_d.phase = PH_CHECK;
                    nxt_d.op    = in_op;
                    nxt_d.a     = a;
                    nxt_d.b     = b;
                    nxt_d.ref_v = dp_y;
                end
            end
            default: begin
                nxt_d.phase  = PH_IDLE;
                nxt_d.done   = 1'b1;
                nxt_d.result = cur_q.ref_v[WIDTH-1:0];
                nxt_d.carry  = cur_q.ref_v[WIDTH];
                nxt_d.error  = (cur_q.ref_v != back_y);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign result = cur_q.result;
    assign carry  = cur_q.carry;
    assign error  = cur_q.error;
    assign done   = cur_q.done;

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_accept_to_check_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_IDLE && start) |=> (cur_q.phase == PH_CHECK));

    p_check_to_done_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_CHECK) |=> done);

    p_hold_outputs_r5: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(carry) && $stable(error)));

    p_ignore_start_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_CHECK && start) |=> (cur_q.phase == PH_IDLE));

    p_clean_no_error_r7: assert property (@(posedge clk) disable iff (rst)
        (done && $past(fault_mask) == '0 && $past(fault_mask, 2) == '0) |-> !error);

    // The spare slice is last in the chain with zero operands: nothing leaves it.
    p_chain_barrier_r11: assert property (@(posedge clk) disable iff (rst)
        !chain_out);
endmodule

// File: tb/sim_rro_alu.sv
`timescale 1ns/1ps
module sim_rro_alu;
    localparam int W  = 8;
    localparam int K  = 3;
    localparam int DW = W + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    op = '0;
    logic [W-1:0]  a = '0, b = '0;
    logic [DW-1:0] fmask = '0, fval = '0;
    logic [W-1:0]  result;
    logic          carry, error, done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rro_alu #(.WIDTH(W), .ROT(K)) u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
        .fault_mask(fmask), .fault_value(fval),
        .result(result), .carry(carry), .error(error), .done(done)
    );

    function automatic logic [DW-1:0] model(input logic [2:0] c,
                                            input logic [W-1:0] x, input logic [W-1:0] y);
        case (c)
            3'd1:    return {1'b0, x | y};
            3'd2:    return {1'b0, x ^ y};
            3'd3:    return {1'b0, x} + {1'b0, y};
            3'd4:    return {1'b0, x} + {1'b0, ~y} + 9'd1;
            default: return {1'b0, x & y};
        endcase
    endfunction

    function automatic logic [DW-1:0] rotr(input logic [DW-1:0] v, input int s);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = v[(i + s) % DW];
        return r;
    endfunction

    function automatic logic [DW-1:0] force_bits(input logic [DW-1:0] v,
                                                 input logic [DW-1:0] m, input logic [DW-1:0] fv);
        return (v & ~m) | (fv & m);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y,
                          input logic [DW-1:0] m, input logic [DW-1:0] fv,
                          output logic [DW-1:0] got, output logic got_err, output logic got_done);
        @(negedge clk);
        start = 1'b1; op = c; a = x; b = y; fmask = m; fval = fv;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        got = {carry, result}; got_err = error; got_done = done;
        fmask = '0; fval = '0;
    endtask

    // Full check of one operation against the model.
    task automatic check_op(input string req, input logic [2:0] c, input logic [W-1:0] x,
                            input logic [W-1:0] y, input logic [DW-1:0] m, input logic [DW-1:0] fv,
                            output logic err_seen);
        logic [DW-1:0] got, tv, r1, r2;
        logic ge, gd;
        run_op(c, x, y, m, fv, got, ge, gd);
        tv = model(c, x, y);
        r1 = force_bits(tv, m, fv);
        r2 = force_bits(tv, rotr(m, K), rotr(fv, K));
        chk({req, " done"}, 32'(gd), 32'd1);
        chk({req, " value"}, 32'(got), 32'(r1));
        chk("R9 error model", 32'(ge), 32'(r1 != r2));
        err_seen = ge;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic e;
        logic [DW-1:0] got;
        logic ge, gd;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 done", 32'(done), 0);
        chk("R12 result", 32'(result), 0);
        chk("R12 carry", 32'(carry), 0);
        chk("R12 error", 32'(error), 0);

        // Directed, fault-free
        check_op("R1 and", 3'd0, 8'hC3, 8'h5A, '0, '0, e);
        check_op("R1 or",  3'd1, 8'hC3, 8'h5A, '0, '0, e);
        check_op("R1 xor", 3'd2, 8'hFF, 8'h0F, '0, '0, e);
        check_op("R2 add carry", 3'd3, 8'hFF, 8'h01, '0, '0, e);
        check_op("R2 add", 3'd3, 8'h12, 8'h34, '0, '0, e);
        check_op("R3 sub borrow", 3'd4, 8'h05, 8'h07, '0, '0, e);
        check_op("R3 sub equal", 3'd4, 8'h07, 8'h07, '0, '0, e);
        check_op("R3 sub zero", 3'd4, 8'h00, 8'hFF, '0, '0, e);
        for (int c = 5; c < 8; c++) begin
            run_op(3'(c), 8'hA6, 8'h6F, '0, '0, got, ge, gd);
            chk("R4 unused code as AND", 32'(got), 32'({1'b0, 8'hA6 & 8'h6F}));
        end

        // R5 hold after done, R6 start during check ignored
        @(negedge clk);
        start = 1'b1; op = 3'd3; a = 8'h80; b = 8'h81;
        @(negedge clk);
        op = 3'd1; a = 8'h00; b = 8'h00;   // start still high in check cycle
        @(negedge clk);
        start = 1'b0;
        chk("R6 done", 32'(done), 1);
        chk("R6 first op value", 32'({carry, result}), 32'(9'h101));
        chk("R6 no error", 32'(error), 0);
        @(negedge clk);
        chk("R6 no second done", 32'(done), 0);
        chk("R5 result held", 32'({carry, result}), 32'(9'h101));
        @(negedge clk);
        chk("R5 still idle", 32'(done), 0);

        // R8 every slice, both stuck values, detected by some pattern
        for (int j = 0; j < DW; j++) begin
            for (int v = 0; v < 2; v++) begin
                logic hit = 1'b0;
                logic [DW-1:0] m = DW'(1) << j;
                logic [DW-1:0] fv = v[0] ? m : '0;
                check_op("R8 stuck", 3'd0, 8'h00, 8'h00, m, fv, e); hit |= e;
                check_op("R8 stuck", 3'd0, 8'hFF, 8'hFF, m, fv, e); hit |= e;
                check_op("R8 stuck", 3'd3, 8'($urandom), 8'($urandom), m, fv, e); hit |= e;
                chk("R8 slice detected", 32'(hit), 1);
            end
        end

        // Random mix: clean runs (R7) and bursts (R10, R11)
        for (int t = 0; t < 300; t++) begin
            logic [2:0] c = 3'($urandom % 8);
            logic [W-1:0] x = 8'($urandom), y = 8'($urandom);
            bit arith = (c == 3'd3 || c == 3'd4);
            if ($urandom % 2 == 0) begin
                check_op("R7 clean", c, x, y, '0, '0, e);
                chk("R7 no error", 32'(e), 0);
            end else begin
                int lim = arith ? (K % DW) - 1 : K % W;
                int len = 1 + int'($urandom % lim);
                int st  = int'($urandom % DW);
                logic [DW-1:0] m = '0;
                logic [DW-1:0] fv = DW'($urandom);
                logic [DW-1:0] tv = model(c, x, y);
                for (int i = 0; i < len; i++) m[(st + i) % DW] = 1'b1;
                check_op(arith ? "R11 burst" : "R10 burst", c, x, y, m, fv, e);
                if (force_bits(tv, m, fv) != tv)
                    chk(arith ? "R11 burst flagged" : "R10 burst flagged", 32'(e), 1);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule